// File: doc/BRIEF.md
# Level-Aware Trap Cause and Threshold CSR Unit

This unit keeps the machine and user trap cause registers and the matching interrupt threshold registers of a hart. The hart can take interrupts in a basic mode or in a level-based mode. The level-based mode applies only when the parameter `LVL_EN` is set and the two low bits of the trap-vector register, brought in on `tvec_mode`, equal `2'b11`. In basic mode a cause register holds only an interrupt flag and an exception code.

In level-based mode a cause register is a composite view. A read also returns the stored previous interrupt level. It also returns the previous-interrupt-enable bit and, for the machine view, the previous-privilege field, both taken from the status register that lives outside this unit. A write stores the level and sends the enable and privilege bits back to the status register through write strobes.

Threshold registers and previous levels force their unimplemented low bits to ones. Software accesses everything through a plain single-cycle CSR port. Reads are combinational, and a write takes effect at the next rising clock edge.

Top module: `lvl_cause_csr`

## Requirements
- R1: After reset, both cause registers read flag 0 and code 0. Both thresholds read `(1<<CTLBITS)-1`, which is 0x0F by default. Both previous levels hold that same value.
- R2: When `LVL_EN` is 0 or `tvec_mode` is not 3, a cause read shows only the flag at bit XLEN-1 and the code at bits CODE_W-1:0. Every other bit reads 0, including bits 29:16, even if those bits were written earlier in level-based mode.
- R3: A machine cause read in level-based mode returns the following fields. The previous level is at bits 23:16. Input `m_pie_i` is at bit 27. Input `m_pp_i` is at bits 29:28. The flag and the code stay in their usual positions.
- R4: A machine cause write in level-based mode stores the flag and the code. It stores `wdata[23:16] | ((1<<(8-CTLBITS))-1)` as the previous level. In the same cycle it raises `m_stat_we`, with `stat_pie_wd = wdata[27]` and `stat_pp_wd = wdata[29:28]`.
- R5: The user cause view has low address byte 0x42 and address bits 9:8 equal to 0. It has its own flag, code and previous level. It shows `u_pie_i` at bit 27, and bits 29:28 read 0. A level-based write raises only `u_stat_we` and leaves the machine state unchanged.
- R6: A threshold write (low address byte 0x47) stores `wdata[7:0] | ((1<<CTLBITS)-1)`. Bits 9:8 of the address select user (0) or machine (other values). The value drives `m_thresh`/`u_thresh` and reads back zero-extended.
- R7: A cause write in basic mode updates only the flag and the code. The previous level does not change, and neither status strobe is raised.
- R8: A change of `tvec_mode` changes the cause read view in the same cycle, without a clock edge.
- R9: Write data bits outside the flag, code, level, enable and privilege fields have no effect. Those bits read as 0.
- R10: Every value of address bits 9:8 other than 0 selects the machine cause register. For example, 0x142, 0x242 and 0x342 read the same machine state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tvec_mode | input | 2 | Low bits of the trap-vector register |
| csr_addr | input | 12 | CSR address |
| csr_we | input | 1 | CSR write enable |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data (combinational) |
| m_pie_i | input | 1 | Machine previous-interrupt-enable from the status register |
| m_pp_i | input | 2 | Machine previous privilege from the status register |
| u_pie_i | input | 1 | User previous-interrupt-enable from the status register |
| m_stat_we | output | 1 | Write strobe for the machine status fields |
| u_stat_we | output | 1 | Write strobe for the user enable bit |
| stat_pie_wd | output | 1 | Previous-interrupt-enable value to write |
| stat_pp_wd | output | 2 | Previous-privilege value to write |
| m_thresh | output | 8 | Machine threshold |
| u_thresh | output | 8 | User threshold |

## Verification
The hardest case to reach is a cause register whose hidden previous level was set in level-based mode and then must stay unchanged through a basic-mode write. That level is invisible while the unit is in basic mode. The stimulus first writes a distinct level in level-based mode. It then writes all ones in basic mode and checks that the upper bits read zero. Finally it switches `tvec_mode` back to 3 within a cycle and checks that the earlier level reappears. The same same-cycle mode switch also proves that the read view depends on `tvec_mode` alone.

// File: rtl/lvl_cause_pkg.sv
package lvl_cause_pkg;
  localparam logic [7:0] CAUSE_LO  = 8'h42;
  localparam logic [7:0] THRESH_LO = 8'h47;
  localparam int LVL_LSB = 16;
  localparam int PIE_BIT = 27;
  localparam int PP_LSB  = 28;
  localparam int NVIEW   = 2;

  typedef enum logic {VIEW_U = 1'b0, VIEW_M = 1'b1} view_e;

  function automatic logic [7:0] low_ones(input int n);
    return 8'(((1 << n) - 1) & 8'hFF);
  endfunction
endpackage

// File: rtl/lvl_csr_decode.sv
module lvl_csr_decode
  import lvl_cause_pkg::*;
(
  input  logic [11:0] addr,
  output logic        is_cause,
  output logic        is_thresh,
  output view_e       view
);
  always_comb begin
    is_cause  = (addr[7:0] == CAUSE_LO);
    is_thresh = (addr[7:0] == THRESH_LO);
    view      = (addr[9:8] == 2'b00) ? VIEW_U : VIEW_M;
  end
endmodule

// File: rtl/lvl_cause_bank.sv
module lvl_cause_bank #(
  parameter int CODE_W  = 4,
  parameter int CTLBITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              lvl_mode,
  input  logic              w_flag,
  input  logic [CODE_W-1:0] w_code,
  input  logic [7:0]        w_lvl,
  output logic              flag,
  output logic [CODE_W-1:0] code,
  output logic [7:0]        prev_lvl,
  output logic              stat_we
);
  import lvl_cause_pkg::*;
  localparam logic [7:0] RST_LVL  = low_ones(CTLBITS);
  localparam logic [7:0] LVL_FILL = low_ones(8 - CTLBITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag     <= 1'b0;
      code     <= '0;
      prev_lvl <= RST_LVL;
    end else if (wr) begin
      flag <= w_flag;
      code <= w_code;
      if (lvl_mode) prev_lvl <= w_lvl | LVL_FILL;
    end
  end

  assign stat_we = wr & lvl_mode;
endmodule

// File: rtl/lvl_thresh_reg.sv
module lvl_thresh_reg #(
  parameter int CTLBITS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] w_val,
  output logic [7:0] thresh
);
  import lvl_cause_pkg::*;
  localparam logic [7:0] FILL = low_ones(CTLBITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  thresh <= FILL;
    else if (wr) thresh <= w_val | FILL;
  end
endmodule

// File: rtl/lvl_cause_csr.sv
module lvl_cause_csr #(
  parameter int XLEN    = 32,
  parameter int MAX_IRQ = 16,
  parameter int CTLBITS = 4,
  parameter bit LVL_EN  = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      tvec_mode,
  input  logic [11:0]     csr_addr,
  input  logic            csr_we,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  input  logic            m_pie_i,
  input  logic [1:0]      m_pp_i,
  input  logic            u_pie_i,
  output logic            m_stat_we,
  output logic            u_stat_we,
  output logic            stat_pie_wd,
  output logic [1:0]      stat_pp_wd,
  output logic [7:0]      m_thresh,
  output logic [7:0]      u_thresh
);
  import lvl_cause_pkg::*;
  localparam int CODE_W = (MAX_IRQ > 1) ? $clog2(MAX_IRQ) : 1;

  logic  is_cause, is_thresh, lvl_mode;
  view_e view;
  logic [NVIEW-1:0]             flag_q, stat_we_v;
  logic [NVIEW-1:0][CODE_W-1:0] code_q;
  logic [NVIEW-1:0][7:0]        prev_lvl, thr_q;

  assign lvl_mode = LVL_EN && (tvec_mode == 2'b11);

  lvl_csr_decode u_dec (
    .addr(csr_addr), .is_cause(is_cause), .is_thresh(is_thresh), .view(view)
  );

  for (genvar g = 0; g < NVIEW; g++) begin : g_view
    logic hit;
    assign hit = (view == view_e'(g));

    lvl_cause_bank #(.CODE_W(CODE_W), .CTLBITS(CTLBITS)) u_cause (
      .clk(clk), .rst_n(rst_n),
      .wr(csr_we & is_cause & hit), .lvl_mode(lvl_mode),
      .w_flag(csr_wdata[XLEN-1]), .w_code(csr_wdata[CODE_W-1:0]),
      .w_lvl(csr_wdata[LVL_LSB+7:LVL_LSB]),
      .flag(flag_q[g]), .code(code_q[g]), .prev_lvl(prev_lvl[g]),
      .stat_we(stat_we_v[g])
    );

    lvl_thresh_reg #(.CTLBITS(CTLBITS)) u_thr (
      .clk(clk), .rst_n(rst_n), .wr(csr_we & is_thresh & hit),
      .w_val(csr_wdata[7:0]), .thresh(thr_q[g])
    );
  end

  assign m_stat_we   = stat_we_v[VIEW_M];
  assign u_stat_we   = stat_we_v[VIEW_U];
  assign stat_pie_wd = csr_wdata[PIE_BIT];
  assign stat_pp_wd  = csr_wdata[PP_LSB+1:PP_LSB];
  assign m_thresh    = thr_q[VIEW_M];
  assign u_thresh    = thr_q[VIEW_U];

  always_comb begin
    csr_rdata = '0;
    if (is_cause) begin
      csr_rdata[XLEN-1]     = flag_q[view];
      csr_rdata[CODE_W-1:0] = code_q[view];
      if (lvl_mode) begin
        csr_rdata[LVL_LSB+7:LVL_LSB] = prev_lvl[view];
        if (view == VIEW_M) begin
          csr_rdata[PIE_BIT]            = m_pie_i;
          csr_rdata[PP_LSB+1:PP_LSB]    = m_pp_i;
        end else begin
          csr_rdata[PIE_BIT]            = u_pie_i;
        end
      end
    end else if (is_thresh) begin
      csr_rdata[7:0] = thr_q[view];
    end
  end

  logic unused_bits;
  assign unused_bits = ^{csr_addr[11:10], csr_wdata};
endmodule

// File: rtl/lvl_cause_csr_chk.sv
module lvl_cause_csr_chk #(
  parameter int XLEN    = 32,
  parameter int CTLBITS = 4,
  parameter bit LVL_EN  = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      tvec_mode,
  input logic [11:0]     csr_addr,
  input logic            csr_we,
  input logic [XLEN-1:0] csr_wdata,
  input logic [XLEN-1:0] csr_rdata,
  input logic            m_stat_we,
  input logic            u_stat_we,
  input logic [7:0]      m_thresh,
  input logic [7:0]      m_prev
);
  localparam logic [7:0] LFILL = 8'(((1 << (8 - CTLBITS)) - 1) & 8'hFF);
  localparam logic [7:0] TFILL = 8'(((1 << CTLBITS) - 1) & 8'hFF);

  logic lvl, cause_a, mview, thr_a;
  assign lvl     = LVL_EN && (tvec_mode == 2'b11);
  assign cause_a = (csr_addr[7:0] == 8'h42);
  assign thr_a   = (csr_addr[7:0] == 8'h47);
  assign mview   = (csr_addr[9:8] != 2'b00);

  a_r4_prev_level: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && cause_a && mview && lvl) |=> (m_prev == ($past(csr_wdata[23:16]) | LFILL)));

  a_r6_thresh_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && thr_a && mview) |=> (m_thresh == ($past(csr_wdata[7:0]) | TFILL)));

  a_r7_no_strobe_basic: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl |-> (!m_stat_we && !u_stat_we));

  a_r7_prev_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && cause_a && mview && !lvl) |=> $stable(m_prev));

  a_r2_basic_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl && cause_a) |-> (csr_rdata[29:16] == '0));

  a_r5_user_no_pp: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl && cause_a && !mview) |-> (csr_rdata[29:28] == 2'b00));

  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({m_stat_we, u_stat_we}) <= 1);
endmodule

bind lvl_cause_csr lvl_cause_csr_chk #(.XLEN(XLEN), .CTLBITS(CTLBITS), .LVL_EN(LVL_EN)) u_chk (
  .clk(clk), .rst_n(rst_n), .tvec_mode(tvec_mode), .csr_addr(csr_addr),
  .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
  .m_stat_we(m_stat_we), .u_stat_we(u_stat_we), .m_thresh(m_thresh),
  .m_prev(prev_lvl[1])
);

// File: tb/lvl_cause_csr_test.sv
module lvl_cause_csr_test;
  logic        clk = 0, rst_n = 0;
  logic [1:0]  tvec_mode = 0;
  logic [11:0] csr_addr = 0;
  logic        csr_we = 0;
  logic [31:0] csr_wdata = 0, csr_rdata;
  logic        m_pie_i, u_pie_i;
  logic [1:0]  m_pp_i;
  logic        m_stat_we, u_stat_we, stat_pie_wd;
  logic [1:0]  stat_pp_wd;
  logic [7:0]  m_thresh, u_thresh;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lvl_cause_csr uut (.*);

  // bench-side status register
  logic b_mpie = 0, b_upie = 0;
  logic [1:0] b_mpp = 0;
  always @(posedge clk) begin
    if (m_stat_we) begin b_mpie <= stat_pie_wd; b_mpp <= stat_pp_wd; end
    if (u_stat_we) b_upie <= stat_pie_wd;
  end
  assign m_pie_i = b_mpie;
  assign m_pp_i  = b_mpp;
  assign u_pie_i = b_upie;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk); csr_addr = a; csr_we = 0; #1;
    chk(req, csr_rdata, exp);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d,
                    input logic exp_m, input logic exp_u, input string req);
    @(negedge clk); csr_addr = a; csr_wdata = d; csr_we = 1; #1;
    chk({req, " strobes"}, {30'd0, m_stat_we, u_stat_we}, {30'd0, exp_m, exp_u});
    @(negedge clk); csr_we = 0;
  endtask

  task automatic t_reset;
    rd("R1 mcause", 12'h342, 32'h0);
    rd("R1 ucause", 12'h042, 32'h0);
    rd("R1 mthresh", 12'h347, 32'h0F);
    chk("R1 uthresh port", {24'd0, u_thresh}, 32'h0F);
    tvec_mode = 2'b11;
    rd("R1 prev level", 12'h342, 32'h000F0000);
  endtask

  task automatic t_machine_lvl;
    tvec_mode = 2'b11;
    wr(12'h342, 32'hFFFF_FFFF, 1, 0, "R4");
    rd("R3 R9 full read", 12'h342, 32'hB8FF000F);
    wr(12'h342, 32'h0012_0005, 1, 0, "R4");
    rd("R4 fill level", 12'h342, 32'h001F0005);
  endtask

  task automatic t_mode_switch;
    @(negedge clk); csr_addr = 12'h342; tvec_mode = 2'b00; #1;
    chk("R8 basic view", csr_rdata, 32'h0000_0005);
    tvec_mode = 2'b11; #1;
    chk("R8 level view", csr_rdata, 32'h001F_0005);
    tvec_mode = 2'b01; #1;
    chk("R2 mode 1 basic", csr_rdata, 32'h0000_0005);
  endtask

  task automatic t_basic_write;
    tvec_mode = 2'b00;
    wr(12'h342, 32'hFFFF_FFFF, 0, 0, "R7");
    rd("R2 basic read", 12'h342, 32'h8000_000F);
    tvec_mode = 2'b11;
    rd("R7 level kept", 12'h342, 32'h801F_000F);
  endtask

  task automatic t_user;
    tvec_mode = 2'b11;
    wr(12'h042, 32'h3A5A_0003, 0, 1, "R5");
    rd("R5 user read", 12'h042, 32'h085F_0003);
    rd("R5 machine untouched", 12'h342, 32'h801F_000F);
  endtask

  task automatic t_alias;
    rd("R10 0x142", 12'h142, 32'h801F_000F);
    rd("R10 0x242", 12'h242, 32'h801F_000F);
  endtask

  task automatic t_thresh;
    wr(12'h347, 32'h1234_5620, 0, 0, "R6");
    rd("R6 mthresh read", 12'h347, 32'h2F);
    chk("R6 mthresh port", {24'd0, m_thresh}, 32'h2F);
    wr(12'h047, 32'h0, 0, 0, "R6");
    chk("R6 uthresh port", {24'd0, u_thresh}, 32'h0F);
    chk("R6 mthresh kept", {24'd0, m_thresh}, 32'h2F);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset;
    t_machine_lvl;
    t_mode_switch;
    t_basic_write;
    t_user;
    t_alias;
    t_thresh;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule